// File: doc/BRIEF.md
# Asynchronous pseudo-SRAM bus controller

This block is a clocked sequencer that talks to a DRAM-backed pseudo-SRAM running in its plain SRAM-compatible asynchronous mode. A host issues single-word reads or writes. Each request carries a 23-bit word address, 16 bits of write data and two byte-enable bits. When the access has finished, the block answers with a one-cycle `done` pulse, and for a read the word appears on `rd_data` in the same cycle.

On the memory side the block drives the active-low strobes: chip enable, output enable, write enable, the two byte selects and address valid. It also drives the address bus and the memory clock, and it controls the direction of the shared 16-bit data bus. Timing is counted in system clock cycles and set by parameters. These cover the power-up hold-off, the read access time, the write-enable low time with its hard ceiling, and the idle gap between accesses. The memory's wait output is left unused, because nothing in this mode depends on it.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset, `mem_ce_n` stays high and `req_ready` stays low for `PWRUP_CYC = CLK_MHZ*PWRUP_US` clock edges. `req_ready` rises one edge later, and no request is accepted before then.
- R2: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for exactly `ACCESS_CYC` cycles. The data bus is sampled at the clock edge that ends the last of those cycles. The sampled word is presented on `rd_data` together with `done`.
- R3: A write holds `mem_ce_n` and `mem_we_n` low and `mem_oe_n` high. `mem_we_n` stays low for exactly `min(WE_CYC, WE_MAX_CYC)` cycles and never longer than `WE_MAX_CYC`.
- R4: The write word stays driven on `mem_dq` for one more cycle after chip enable, write enable and the byte selects have all returned high.
- R5: `mem_adv_n` is low in every cycle in which `mem_ce_n` is low, and it is high otherwise.
- R6: `mem_clk` is low at all times.
- R7: The `mem_wait` input has no effect: reads return the stored word whatever `mem_wait` does.
- R8: `req_be[0]` selects the lower byte (bits 7:0, strobe `mem_lb_n`) and `req_be[1]` selects the upper byte (bits 15:8, strobe `mem_ub_n`). A cleared bit keeps its strobe high for the whole access, so on a write that byte of memory is left unchanged.
- R9: The block drives `mem_dq` only during the write phase and the hold cycle after it. In the cycle just before `mem_oe_n` falls, the bus is released (high impedance).
- R10: Between two accesses `mem_ce_n` is high for at least `GAP_CYC` cycles. Each accepted request yields exactly one `done` pulse, one cycle wide.
- R11: During an access, `mem_addr` carries the address of the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte |
| req_ready | output | 1 | Block is idle and past the power-up hold-off |
| rd_data | output | 16 | Read word, valid with `done` after a read |
| done | output | 1 | One-cycle pulse per completed request |
| mem_clk | output | 1 | Memory clock, held low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_addr | output | 23 | Memory word address |
| mem_dq | inout | 16 | Bidirectional data bus |
| mem_wait | input | 1 | Memory wait output, ignored |

## Verification
Directed accesses come first. Full-word writes and reads go to the lowest and highest addresses, telling correct address routing apart from truncated bits. Single-byte writes with each enable, and a write with both enables cleared, show that only the selected byte strobes fall and only those bytes change. A write followed immediately by a read to the same address exposes bus turnaround contention and a missing data hold. After that, a long run of random reads and writes with random byte enables over a small address pool, with the wait pin toggling randomly, is compared against a shadow memory. The memory model returns garbage before the access time has elapsed, so an early sample is detected.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_WHOLD,
    ST_GAP
  } phase_e;

  function automatic int clamp_len(input int want, input int lo, input int hi);
    int r;
    r = want;
    if (r < lo) r = lo;
    if (r > hi) r = hi;
    return r;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int r;
    r = a;
    if (b > r) r = b;
    if (c > r) r = c;
    return r;
  endfunction

endpackage

// File: rtl/psram_pwrup.sv
module psram_pwrup #(
  parameter int HOLD_CYC = 37500
) (
  input  logic clk,
  input  logic rst,
  output logic ok
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ok  <= 1'b0;
    end else if (!ok) begin
      if (cnt == CW'(HOLD_CYC - 1)) ok <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/psram_phase_cnt.sv
module psram_phase_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (ld)         cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/psram_dq_path.sv
module psram_dq_path #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          drive_nx,
  input  logic          cap,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o    <= '0;
      dq_oe   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (load) dq_o <= load_data;
      dq_oe <= drive_nx;
      if (cap) rd_data <= bus_in;
    end
  end
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
  import psram_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int PWRUP_US   = 150,
  parameter int ACCESS_CYC = 18,
  parameter int WE_CYC     = 12,
  parameter int WE_MAX_CYC = 16,
  parameter int GAP_CYC    = 2,
  parameter int ADDR_W     = 23,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              mem_clk,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic              mem_adv_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  input  logic              mem_wait
);
  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int ACC_LEN   = clamp_len(ACCESS_CYC, 1, ACCESS_CYC + 1);
  localparam int WE_LEN    = clamp_len(WE_CYC, 1, (WE_MAX_CYC < 1) ? 1 : WE_MAX_CYC);
  localparam int GAP_LEN   = clamp_len(GAP_CYC, 1, GAP_CYC + 1);
  localparam int MAX_LEN   = max3(ACC_LEN, WE_LEN, GAP_LEN);
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam int BE_W      = 2;

  phase_e           state, state_nx;
  logic             pwr_ok;
  logic             accept;
  logic             ph_ld, ph_zero;
  logic [CNT_W-1:0] ph_val;
  logic [BE_W-1:0]  be_q, be_use;
  logic [BE_W-1:0]  strb_n;
  logic             act_nx;
  logic             drive_nx, cap;
  logic [DATA_W-1:0] dq_o;
  logic             dq_oe;
  logic             unused_wait;

  assign unused_wait = mem_wait;

  psram_pwrup #(.HOLD_CYC(PWRUP_CYC)) u_pwrup (
    .clk (clk),
    .rst (rst),
    .ok  (pwr_ok)
  );

  psram_phase_cnt #(.W(CNT_W)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .ld     (ph_ld),
    .ld_val (ph_val),
    .zero   (ph_zero)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_nx = state;
    ph_ld    = 1'b0;
    ph_val   = '0;
    unique case (state)
      ST_INIT: if (pwr_ok) state_nx = ST_IDLE;
      ST_IDLE: if (req_valid) begin
        ph_ld = 1'b1;
        if (req_write) begin
          state_nx = ST_WRITE;
          ph_val   = CNT_W'(WE_LEN - 1);
        end else begin
          state_nx = ST_READ;
          ph_val   = CNT_W'(ACC_LEN - 1);
        end
      end
      ST_READ: if (ph_zero) begin
        state_nx = ST_GAP;
        ph_ld    = 1'b1;
        ph_val   = CNT_W'(GAP_LEN - 1);
      end
      ST_WRITE: if (ph_zero) state_nx = ST_WHOLD;
      ST_WHOLD: begin
        state_nx = ST_GAP;
        ph_ld    = 1'b1;
        ph_val   = CNT_W'(GAP_LEN - 1);
      end
      ST_GAP: if (ph_zero) state_nx = ST_IDLE;
      default: state_nx = ST_INIT;
    endcase
  end

  assign act_nx   = (state_nx == ST_READ) || (state_nx == ST_WRITE);
  assign be_use   = accept ? req_be : be_q;
  assign drive_nx = (state_nx == ST_WRITE) || (state_nx == ST_WHOLD);
  assign cap      = (state == ST_READ) && ph_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      be_q      <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_adv_n <= 1'b1;
      done      <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        be_q     <= req_be;
        mem_addr <= req_addr;
      end
      mem_ce_n  <= !act_nx;
      mem_adv_n <= !act_nx;
      mem_oe_n  <= !(state_nx == ST_READ);
      mem_we_n  <= !(state_nx == ST_WRITE);
      done      <= cap || (state == ST_WHOLD);
    end
  end

  for (genvar i = 0; i < BE_W; i++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) strb_n[i] <= 1'b1;
      else     strb_n[i] <= !(act_nx && be_use[i]);
    end
  end

  assign mem_lb_n = strb_n[0];
  assign mem_ub_n = strb_n[1];
  assign mem_clk  = 1'b0;

  psram_dq_path #(.DW(DATA_W)) u_dq (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (req_wdata),
    .drive_nx  (drive_nx),
    .cap       (cap),
    .bus_in    (mem_dq),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe),
    .rd_data   (rd_data)
  );

  assign mem_dq = dq_oe ? dq_o : {DATA_W{1'bz}};
endmodule

// File: rtl/psram_async_ctrl_chk.sv
module psram_async_ctrl_chk #(
  parameter int HOLD_CYC = 37500,
  parameter int WE_MAX   = 16
) (
  input logic clk,
  input logic rst,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_adv_n,
  input logic req_ready,
  input logic done
);
  localparam int SW = $clog2(HOLD_CYC + 2);
  localparam int WW = $clog2(WE_MAX + 2);

  logic [SW-1:0] since;
  logic [WW-1:0] we_run;

  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since < SW'(HOLD_CYC)) since <= since + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            we_run <= '0;
    else if (!mem_we_n) we_run <= (we_run < WW'(WE_MAX + 1)) ? we_run + 1'b1 : we_run;
    else                we_run <= '0;
  end

  assert_holdoff_R1: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> (since >= SW'(HOLD_CYC)));

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_ce_n);

  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  assert_we_over_oe_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  assert_we_cap_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (we_run < WW'(WE_MAX)));

  assert_adv_low_R5: assert property (@(posedge clk) disable iff (rst)
    mem_adv_n == mem_ce_n);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_access_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> mem_ce_n);
endmodule

bind psram_async_ctrl psram_async_ctrl_chk #(
  .HOLD_CYC (PWRUP_CYC),
  .WE_MAX   (WE_MAX_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_adv_n (mem_adv_n),
  .req_ready (req_ready),
  .done      (done)
);

// File: tb/sim_psram_async_ctrl.sv
`timescale 1ns/1ps
module sim_psram_async_ctrl;
  localparam int HOLD   = 250 * 150;
  localparam int ACC    = 18;
  localparam int WE_LEN = 12;
  localparam int GAP    = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, done;
  logic [15:0] rd_data;
  logic        mem_clk, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_adv_n;
  logic [22:0] mem_addr;
  wire  [15:0] mem_dq;
  logic        mem_wait = 1'b0;

  always #2 clk = ~clk;

  psram_async_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rd_data(rd_data), .done(done),
    .mem_clk(mem_clk), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_adv_n(mem_adv_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .mem_wait(mem_wait)
  );

  int n_chk = 0, n_fail = 0, n_req = 0, n_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and shadow memory
  logic [15:0] mdl  [int unsigned];
  logic [15:0] shad [int unsigned];

  function automatic logic [15:0] seed_word(input logic [22:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] mdl_rd(input logic [22:0] a);
    return mdl.exists(a) ? mdl[a] : seed_word(a);
  endfunction
  function automatic logic [15:0] exp_rd(input logic [22:0] a);
    return shad.exists(a) ? shad[a] : seed_word(a);
  endfunction

  logic [15:0] mdl_out = 16'h0;
  wire mdl_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq = mdl_drv ? mdl_out : 16'hzzzz;

  // current request seen by the monitor
  logic        cur_wr = 1'b0;
  logic [22:0] cur_addr = '0;
  logic [15:0] cur_wdata = '0;
  logic [1:0]  cur_be = '0;

  int   acc_cnt = 0, we_run = 0, ce_hi_run = 1000;
  bit   p_wr_lo = 0, p_wr_hi = 0, prev_dq_z = 1, prev_oe_n = 1, prev_done = 0, seen_ready = 0;
  logic [22:0] p_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      bit wr_lo, wr_hi;
      logic [15:0] t;
      mem_wait = $urandom_range(0, 1);
      // model: data only valid once the access time has elapsed
      if (mem_ce_n) acc_cnt = 0; else acc_cnt = acc_cnt + 1;
      mdl_out = (acc_cnt >= ACC) ? mdl_rd(mem_addr) : (16'hBAD0 ^ mem_addr[15:0]);
      // model: capture each byte on the first rising of its write strobes
      wr_lo = !mem_ce_n && !mem_we_n && !mem_lb_n;
      wr_hi = !mem_ce_n && !mem_we_n && !mem_ub_n;
      if (p_wr_lo && !wr_lo) begin t = mdl_rd(p_addr); t[7:0]  = mem_dq[7:0];  mdl[p_addr] = t; end
      if (p_wr_hi && !wr_hi) begin t = mdl_rd(p_addr); t[15:8] = mem_dq[15:8]; mdl[p_addr] = t; end
      p_wr_lo = wr_lo; p_wr_hi = wr_hi; p_addr = mem_addr;

      if (mem_clk !== 1'b0) chk(0, "R6 memory clock low", {31'd0, mem_clk}, 32'd0);
      if (req_ready) seen_ready = 1;
      if (!seen_ready && !mem_ce_n) chk(0, "R1 chip enable during hold-off", 32'd0, 32'd1);
      chk(mem_adv_n == mem_ce_n, "R5 address valid follows chip enable", {31'd0, mem_adv_n}, {31'd0, mem_ce_n});
      if (!mem_ce_n) begin
        chk(mem_lb_n == !cur_be[0], "R8 lower byte strobe", {31'd0, mem_lb_n}, {31'd0, !cur_be[0]});
        chk(mem_ub_n == !cur_be[1], "R8 upper byte strobe", {31'd0, mem_ub_n}, {31'd0, !cur_be[1]});
        chk(mem_addr == cur_addr, "R11 address bus", {9'd0, mem_addr}, {9'd0, cur_addr});
        chk(mem_we_n == !cur_wr, "R3 write enable level", {31'd0, mem_we_n}, {31'd0, !cur_wr});
        chk(mem_oe_n == cur_wr, "R2 output enable level", {31'd0, mem_oe_n}, {31'd0, cur_wr});
      end
      if (!mem_we_n) we_run++;
      else if (we_run > 0) begin
        chk(we_run == WE_LEN, "R3 write enable low time", we_run, WE_LEN);
        chk(mem_dq === cur_wdata, "R4 write data held after strobes rise", {16'd0, mem_dq}, {16'd0, cur_wdata});
        we_run = 0;
      end
      if (mem_ce_n) ce_hi_run++;
      else begin
        if (ce_hi_run > 0) chk(ce_hi_run >= GAP, "R10 recovery gap", ce_hi_run, GAP);
        ce_hi_run = 0;
      end
      if (!mem_oe_n && prev_oe_n)
        chk(prev_dq_z, "R9 bus released before output enable", {31'd0, prev_dq_z}, 32'd1);
      if (done) n_done++;
      if (done && prev_done) chk(0, "R10 done wider than one cycle", 32'd2, 32'd1);
      prev_done = done; prev_oe_n = mem_oe_n;
      prev_dq_z = (mem_dq === 16'hzzzz);
    end
  end

  task automatic do_op(input bit wr, input logic [22:0] a, input logic [15:0] d, input logic [1:0] be, input string tag);
    int w;
    while (!req_ready) @(negedge clk);
    cur_wr = wr; cur_addr = a; cur_wdata = d; cur_be = be;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    n_req++;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done && w < 200) begin @(negedge clk); w++; end
    chk(done, {tag, " done pulse"}, {31'd0, done}, 32'd1);
    if (wr) begin
      logic [15:0] t;
      t = exp_rd(a);
      if (be[0]) t[7:0]  = d[7:0];
      if (be[1]) t[15:8] = d[15:8];
      shad[a] = t;
    end else begin
      chk(rd_data == exp_rd(a), {tag, " read data"}, {16'd0, rd_data}, {16'd0, exp_rd(a)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !done && !req_ready,
        "R1 reset state", {27'd0, mem_ce_n, mem_oe_n, mem_we_n, done, req_ready}, 32'h1C);
    chk(mem_clk == 1'b0, "R6 clock at reset", {31'd0, mem_clk}, 32'd0);
    rst = 1'b0;
    repeat (HOLD) @(negedge clk);
    chk(!req_ready && mem_ce_n, "R1 still holding off", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk(req_ready, "R1 ready after hold-off", {31'd0, req_ready}, 32'd1);

    do_op(1, 23'h000000, 16'h1234, 2'b11, "R3 write low address");
    do_op(0, 23'h000000, 16'h0000, 2'b11, "R2 read low address");
    do_op(1, 23'h7FFFFF, 16'hFEDC, 2'b11, "R11 write top address");
    do_op(0, 23'h7FFFFF, 16'h0000, 2'b11, "R11 read top address");
    do_op(1, 23'h000005, 16'hABCD, 2'b01, "R8 lower byte only");
    do_op(0, 23'h000005, 16'h0000, 2'b11, "R8 read after lower byte");
    do_op(1, 23'h000006, 16'h9876, 2'b10, "R8 upper byte only");
    do_op(0, 23'h000006, 16'h0000, 2'b11, "R8 read after upper byte");
    do_op(1, 23'h000000, 16'hFFFF, 2'b00, "R8 no byte enabled");
    do_op(0, 23'h000000, 16'h0000, 2'b11, "R8 read after empty write");
    do_op(1, 23'h000010, 16'h0F0F, 2'b11, "R9 write before turnaround");
    do_op(0, 23'h000010, 16'h0000, 2'b01, "R9 read right after write");

    for (int i = 0; i < 300; i++) begin
      logic [22:0] a;
      a = 23'($urandom_range(0, 31)) | (($urandom_range(0, 1) != 0) ? 23'h7FFFE0 : 23'h0);
      do_op($urandom_range(0, 1) != 0, a, 16'($urandom), 2'($urandom_range(0, 3)), "R7 random access");
    end

    repeat (10) @(negedge clk);
    chk(n_done == n_req, "R10 one done per request", n_done, n_req);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule